// File: doc/BRIEF.md
# Host Supervision Watchdog with Power-Up Reset

This block watches over a host processor. It counts clock cycles since the host last serviced it. If the count reaches the interval the host chose, it asserts a reset line. The host services the block by driving a falling edge on a strobe input. The interval comes from a two-bit selection held in a register that has no reset. A loss of power-good therefore leaves the choice intact. The selection offers three interval lengths and an off setting.

When power-good goes high, the block holds reset for a fixed number of cycles before it releases the line. After a timeout, the reset pulse has that same fixed length, and counting then starts again from zero. The reset line is open drain. The block gives out a drive enable, and also the line level that results when the released line rests at its inactive level. A parameter sets whether the asserted level is low or high. Interval and pulse lengths are parameters counted in clock cycles.

Top module: `hwdog_supervisor`

## Requirements
- R1: While power-good is sampled low at a clock edge, the reset drive enable is high after that edge.
- R2: Once power-good is high, reset stays asserted through exactly PULSE_CYC rising edges and is released at the PULSE_CYC-th one.
- R3: Select code 2'b00 picks T_SHORT, 2'b01 picks T_MID and 2'b10 picks T_LONG. Take the edge that released reset, or the edge that saw a service fall, as edge 0. With no service after it, reset asserts at edge N of the chosen interval N, and not before.
- R4: Select code 2'b11 disables the timeout: reset is never asserted by the timer. After a write back to an enabled code, the full interval is counted from the write edge.
- R5: A service is a high-to-low change of the strobe between two edges, and it restarts the count from zero. A rising edge, or a strobe held high, does not restart it.
- R6: A timeout holds reset for exactly PULSE_CYC edges. The next timeout then comes a full interval after the release.
- R7: A service falling edge while reset is asserted changes neither the pulse length nor the interval counted after the release.
- R8: The select is loaded from the select input at an edge where the write strobe is high, and only then. Power-good going low does not change it.
- R9: When reset is asserted, the drive enable is 1 and the line equals the asserted level (0 when ACTIVE_HIGH is 0, 1 when it is 1). When released, the enable is 0 and the line rests at the opposite level.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_i | input | 1 | Power valid; low acts as a synchronous active-low reset |
| svc_i | input | 1 | Service strobe; its falling edge restarts the count |
| sel_i | input | 2 | Interval select value to be stored |
| sel_wr_i | input | 1 | Loads sel_i into the retained select register |
| rst_oe_o | output | 1 | Open-drain drive enable; 1 while reset is asserted |
| rst_o | output | 1 | Resolved reset line level at the selected polarity |

## Verification
A count that is off by one in the timer shows on the line as a timeout that comes one cycle early or late, within a single interval. The bench samples the cycle on each side of the expected edge, so it sees this at once. A pulse counter that is stuck or wrong shows within one pulse as a release that is too early or never comes. If the retained select is lost or corrupted, the next window after power-up has the wrong length, and the first timeout reveals it. Two instances of opposite polarity run side by side, so an inverted line level shows on the first check of reset.

// File: rtl/hwdog_pkg.sv
// Package: shared select encoding for the watchdog supervisor.
// Assumes: a two-bit select, where the top code turns the timer off.
package hwdog_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'b00,
        SEL_MID   = 2'b01,
        SEL_LONG  = 2'b10,
        SEL_OFF   = 2'b11
    } hwdog_sel_e;

endpackage

// File: rtl/hwdog_sel_store.sv
// Retained interval select register.
// Assumes: its contents are meant to survive power-good loss, so it has no
// reset; the host must write it before relying on it.
module hwdog_sel_store
    import hwdog_pkg::*;
(
    input  logic       clk,
    input  logic       wr_i,
    input  logic [1:0] sel_i,
    output hwdog_sel_e sel_o
);

    hwdog_sel_e sel_q;

    // Capture a new select only on an explicit write strobe.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            sel_q <= hwdog_sel_e'(sel_i);
        end
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/hwdog_svc_edge.sv
// Service strobe falling-edge detector.
// Assumes: svc_i is synchronous to clk; the history bit is cleared in reset,
// so a strobe held low through power-up raises no service.
module hwdog_svc_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic svc_i,
    output logic fall_o
);

    logic svc_q;

    // Keep the previous strobe level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= 1'b0;
        end else begin
            svc_q <= svc_i;
        end
    end

    assign fall_o = svc_q & ~svc_i;

endmodule

// File: rtl/hwdog_interval_timer.sv
// Timeout counter: counts cycles while running and flags expiry on the
// cycle in which the selected interval is used up.
// Assumes: all intervals are at least 1; hold_i keeps the count at zero
// (used while reset is asserted); clear_i restarts it.
module hwdog_interval_timer
    import hwdog_pkg::*;
#(
    parameter int unsigned T_SHORT = 2000,
    parameter int unsigned T_MID   = 8000,
    parameter int unsigned T_LONG  = 32000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_i,
    input  logic       clear_i,
    input  hwdog_sel_e sel_i,
    output logic       expire_o
);

    localparam int unsigned T_MAX_SM = (T_SHORT > T_MID) ? T_SHORT : T_MID;
    localparam int unsigned T_MAX    = (T_MAX_SM > T_LONG) ? T_MAX_SM : T_LONG;
    localparam int unsigned CW       = $clog2(T_MAX + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic          run;

    // Map the select code to the last count value of its interval.
    always_comb begin
        case (sel_i)
            SEL_SHORT: lim_m1 = CW'(T_SHORT - 1);
            SEL_MID:   lim_m1 = CW'(T_MID - 1);
            SEL_LONG:  lim_m1 = CW'(T_LONG - 1);
            default:   lim_m1 = '0;
        endcase
    end

    // Decide whether counting is live and whether the window is exhausted.
    always_comb begin
        run      = !hold_i && (sel_i != SEL_OFF);
        expire_o = run && !clear_i && (cnt_q >= lim_m1);
    end

    // Advance, restart or hold the elapsed-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || clear_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/hwdog_rst_pulse.sv
// Reset pulse generator: holds the reset request for PULSE_CYC cycles,
// both after power-good rises and after each trigger.
// Assumes: PULSE_CYC >= 1; triggers arriving during a pulse are dropped.
module hwdog_rst_pulse #(
    parameter int unsigned PULSE_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger_i,
    output logic active_o
);

    localparam int unsigned PW = $clog2(PULSE_CYC + 1);

    logic [PW-1:0] cnt_q;
    logic          active_q;

    // Start, time and end each reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == PW'(PULSE_CYC - 1)) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + PW'(1);
            end
        end else if (trigger_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/hwdog_supervisor.sv
// Watchdog supervisor top: power-up reset pulse, retained interval select,
// service-restarted timeout and an open-drain reset output of either
// polarity.
// Assumes: all inputs are synchronous to clk; pwr_good_i low is the
// synchronous active-low reset of everything except the select register.
module hwdog_supervisor
    import hwdog_pkg::*;
#(
    parameter int unsigned T_SHORT     = 2000,
    parameter int unsigned T_MID       = 8000,
    parameter int unsigned T_LONG      = 32000,
    parameter int unsigned PULSE_CYC   = 400,
    parameter bit          ACTIVE_HIGH = 1'b0
) (
    input  logic       clk,
    input  logic       pwr_good_i,
    input  logic       svc_i,
    input  logic [1:0] sel_i,
    input  logic       sel_wr_i,
    output logic       rst_oe_o,
    output logic       rst_o
);

    hwdog_sel_e sel_q;
    logic       svc_fall;
    logic       expire;
    logic       rst_active;

    hwdog_sel_store u_sel (
        .clk   (clk),
        .wr_i  (sel_wr_i),
        .sel_i (sel_i),
        .sel_o (sel_q)
    );

    hwdog_svc_edge u_svc (
        .clk    (clk),
        .rst_n  (pwr_good_i),
        .svc_i  (svc_i),
        .fall_o (svc_fall)
    );

    hwdog_interval_timer #(
        .T_SHORT (T_SHORT),
        .T_MID   (T_MID),
        .T_LONG  (T_LONG)
    ) u_timer (
        .clk      (clk),
        .rst_n    (pwr_good_i),
        .hold_i   (rst_active),
        .clear_i  (svc_fall),
        .sel_i    (sel_q),
        .expire_o (expire)
    );

    hwdog_rst_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (pwr_good_i),
        .trigger_i (expire),
        .active_o  (rst_active)
    );

    assign rst_oe_o = rst_active;

    // Resolve the line level for the chosen polarity.
    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign rst_o = rst_active;
        end else begin : g_pol_low
            assign rst_o = ~rst_active;
        end
    endgenerate

endmodule

// File: rtl/hwdog_sva.sv
// Checker for the watchdog supervisor, bound to every instance of the top.
// Assumes: the select is not changed while the timer is counting a window.
module hwdog_sva #(
    parameter int unsigned T_SHORT   = 2000,
    parameter int unsigned T_MID     = 8000,
    parameter int unsigned T_LONG    = 32000,
    parameter int unsigned PULSE_CYC = 400
) (
    input logic       clk,
    input logic       pwr_good_i,
    input logic       svc_i,
    input logic       rst_oe_o,
    input logic [1:0] sel_q
);

    logic        svc_prev;
    int unsigned hi_run;
    int unsigned lo_run;
    int unsigned lim_now;

    // Track the strobe history, and the lengths of asserted and released runs.
    always_ff @(posedge clk) begin
        if (!pwr_good_i) begin
            svc_prev <= 1'b0;
            hi_run   <= 0;
            lo_run   <= 0;
        end else begin
            svc_prev <= svc_i;
            hi_run   <= rst_oe_o ? hi_run + 1 : 0;
            if (rst_oe_o || sel_q == 2'b11 || (svc_prev && !svc_i)) begin
                lo_run <= 0;
            end else begin
                lo_run <= lo_run + 1;
            end
        end
    end

    // Interval length for the current select.
    always_comb begin
        case (sel_q)
            2'b00:   lim_now = T_SHORT;
            2'b01:   lim_now = T_MID;
            2'b10:   lim_now = T_LONG;
            default: lim_now = 0;
        endcase
    end

    AST_PWR_LOW_ASSERTS: assert property (@(posedge clk)
        !pwr_good_i |=> rst_oe_o);  // R1

    AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (!pwr_good_i)
        $fell(rst_oe_o) |-> hi_run == PULSE_CYC);  // R6

    AST_TIMEOUT_WINDOW: assert property (@(posedge clk) disable iff (!pwr_good_i)
        $rose(rst_oe_o) && $past(pwr_good_i) |-> lo_run == lim_now);  // R3

    AST_OFF_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!pwr_good_i)
        !rst_oe_o && sel_q == 2'b11 |=> !rst_oe_o);  // R4

endmodule

bind hwdog_supervisor hwdog_sva #(
    .T_SHORT   (T_SHORT),
    .T_MID     (T_MID),
    .T_LONG    (T_LONG),
    .PULSE_CYC (PULSE_CYC)
) u_sva (
    .clk        (clk),
    .pwr_good_i (pwr_good_i),
    .svc_i      (svc_i),
    .rst_oe_o   (rst_oe_o),
    .sel_q      (sel_q)
);

// File: tb/hwdog_supervisor_test.sv
`timescale 1ns/1ps
module hwdog_supervisor_test;

    localparam int unsigned TS = 10;
    localparam int unsigned TM = 16;
    localparam int unsigned TL = 24;
    localparam int unsigned PC = 5;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       svc = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       sel_wr = 1'b0;
    logic       oe_lo, line_lo, oe_hi, line_hi;
    int         checks = 0;
    int         fails = 0;

    always #2.5 clk = ~clk;

    hwdog_supervisor #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .PULSE_CYC(PC),
                       .ACTIVE_HIGH(1'b0)) uut (
        .clk(clk), .pwr_good_i(pwr_good), .svc_i(svc), .sel_i(sel),
        .sel_wr_i(sel_wr), .rst_oe_o(oe_lo), .rst_o(line_lo));

    hwdog_supervisor #(.T_SHORT(TS), .T_MID(TM), .T_LONG(TL), .PULSE_CYC(PC),
                       .ACTIVE_HIGH(1'b1)) uut_hi (
        .clk(clk), .pwr_good_i(pwr_good), .svc_i(svc), .sel_i(sel),
        .sel_wr_i(sel_wr), .rst_oe_o(oe_hi), .rst_o(line_hi));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset state of both instances, with line polarity (R9).
    task automatic chk_rst(input string req, input logic on);
        chk(req, "oe active-low", oe_lo, on);
        chk(req, "oe active-high", oe_hi, on);
        chk("R9", "line active-low", line_lo, ~on);
        chk("R9", "line active-high", line_hi, on);
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel = v; sel_wr = 1'b1;
        tick(1);
        sel_wr = 1'b0;
    endtask

    task automatic service();
        svc = 1'b1; tick(1);
        svc = 1'b0; tick(1);
    endtask

    // Called just after the asserting edge, with 'used' ticks already spent.
    task automatic pulse_release(input string req, input int used);
        tick(PC - 1 - used); chk_rst(req, 1'b1);
        tick(1);             chk_rst(req, 1'b0);
    endtask

    // Called after edge 0 of a window, with 'used' ticks already spent.
    task automatic window(input string req, input int lim, input int used);
        tick(lim - 1 - used); chk_rst(req, 1'b0);
        tick(1);              chk_rst(req, 1'b1);
    endtask

    task automatic t_powerup();
        write_sel(2'b00);
        tick(2);
        chk_rst("R1", 1'b1);
        pwr_good = 1'b1;
        pulse_release("R2", 0);
        window("R3", TS, 0);
    endtask

    task automatic t_intervals();
        write_sel(2'b01); pulse_release("R6", 1); window("R3", TM, 0);
        write_sel(2'b10); pulse_release("R6", 1); window("R3", TL, 0);
        write_sel(2'b00); pulse_release("R6", 1); window("R3", TS, 0);
    endtask

    task automatic t_service();
        pulse_release("R6", 0);
        tick(4); service();
        window("R5", TS, 0);
        pulse_release("R6", 0);
        tick(2); svc = 1'b1;
        window("R5", TS, 2);
        tick(1); svc = 1'b0;
        pulse_release("R7", 1);
        window("R7", TS, 0);
    endtask

    task automatic t_disable();
        logic seen;
        seen = 1'b0;
        write_sel(2'b11);
        pulse_release("R4", 1);
        for (int i = 0; i < 3 * TL; i++) begin
            tick(1);
            if (oe_lo || oe_hi) seen = 1'b1;
        end
        chk("R4", "no timeout while off", seen, 1'b0);
        write_sel(2'b00);
        window("R4", TS, 0);
    endtask

    task automatic t_retain();
        write_sel(2'b10);
        pwr_good = 1'b0;
        tick(3);
        chk_rst("R1", 1'b1);
        pwr_good = 1'b1;
        pulse_release("R2", 0);
        window("R8", TL, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_powerup();
        t_intervals();
        t_service();
        t_disable();
        t_retain();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule